// File: doc/BRIEF.md
# Two-Wire Digital Potentiometer Command Slave

This block is the serial front end of a single 1024-step digital potentiometer. It watches a two-wire bus (SCL and SDA), spots start and stop conditions, checks an identification byte against a fixed type code and two strapped address pins, and acknowledges the bytes it accepts. It then decodes an instruction byte that carries an opcode and a register select. Reads, writes and register-to-register copies go out to an external register bank as single-cycle requests on a parallel port. Read data is shifted back to the bus master.

The bank owns the wiper counter register and four data registers, and it reports when a nonvolatile write is in progress. Two commands store into nonvolatile data registers: writing a data register and copying the wiper into a data register. These are launched only when the stop condition closes the command. While the bank reports busy, the slave leaves its identification byte unacknowledged. A master can therefore poll with repeated starts until the slave answers again. The open-drain output is one signal, `sda_low`: when it is high, the pad pulls SDA to ground.

Top module: `potctl_slave`

## Requirements
- R1: The identification byte is accepted only when bits [7:4] equal 0101 and bits [3:2] equal `dev_pins`. Bit 0 is read/not-write and bit 1 is ignored. An accepted byte is acknowledged by holding SDA low through the ninth clock. A rejected byte gets no acknowledge, and no byte of the rest of that transaction is acknowledged or causes a request.
- R2: `sda_low` changes only after an SCL falling edge, so SDA never moves under the slave's control while SCL is high.
- R3: While `nv_busy` is high when the identification byte completes, that byte is not acknowledged.
- R4: In the instruction byte, bits [7:5] are the opcode and bits [1:0] select a data register; bits [4:2] are ignored. Opcodes 000 and 001 are undefined: they are not acknowledged and produce no request.
- R5: Opcode 110 writes the wiper. It takes two data bytes, each acknowledged, and forms the value {first[1:0], second[7:0]}; the upper six bits of the first byte are ignored. The request with op 110 is issued right after the second byte, before any stop.
- R6: Opcodes 111 (write data register, same two-byte data format as R5) and 011 (copy wiper into data register) issue their request only on the stop condition. If a start condition comes first, the command is dropped.
- R7: Opcodes 101 (read wiper) and 100 (read selected data register) issue a read request. The slave then sends {000000, d[9:8]} followed by d[7:0], MSB first. A master non-acknowledge after the first byte ends the transfer.
- R8: An identification byte with read/not-write = 1 skips the instruction byte. It requests a wiper read (op 101) and sends the value in the two-byte format of R7.
- R9: Opcode 010 (copy selected data register into the wiper) issues its request right after the instruction byte, before any stop.
- R10: `req_valid` is a one-cycle pulse, with `req_op`, `req_sel` and `req_wdata` valid in the same cycle. `rd_data` is taken in that cycle.
- R11: After reset, `sda_low` is low and no request is pending. While the bus is idle, `sda_low` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock from the pad |
| sda_in | input | 1 | Serial data as seen on the wired bus |
| dev_pins | input | 2 | Strapped address bits compared with the identification byte |
| nv_busy | input | 1 | Bank is busy with a nonvolatile write |
| rd_data | input | 10 | Read data from the bank, valid while `req_valid` is high |
| sda_low | output | 1 | Pull SDA low (acknowledge or a zero data bit) |
| req_valid | output | 1 | One-cycle request strobe to the bank |
| req_op | output | 3 | Opcode of the request |
| req_sel | output | 2 | Data register select |
| req_wdata | output | 10 | Value to write |

## Verification
The hardest case to reach is the busy window: the moment right after a stop has launched a nonvolatile store, when the slave must refuse its own address. The bench models a bank that raises its busy flag for a fixed number of cycles after each store request. Immediately after the stop that ends a data-register write, it issues a new start and identification byte and expects no acknowledge. It then waits for the busy window to end and polls again, expecting an acknowledge. A second hard case is a store that is abandoned by a repeated start. The bench reaches it by following the copy instruction with a new start instead of a stop, and then confirms that no request ever appears.

// File: rtl/potctl_pkg.sv
// Package: opcode values and protocol engine states shared by the
// potentiometer command slave and its checker.
package potctl_pkg;
    localparam logic [2:0] OP_XF_D2W  = 3'b010;
    localparam logic [2:0] OP_XF_W2D  = 3'b011;
    localparam logic [2:0] OP_RD_DR   = 3'b100;
    localparam logic [2:0] OP_RD_WIP  = 3'b101;
    localparam logic [2:0] OP_WR_WIP  = 3'b110;
    localparam logic [2:0] OP_WR_DR   = 3'b111;

    typedef enum logic [2:0] {
        S_IDLE, S_ID, S_INSTR, S_WHI, S_WLO, S_RHI, S_RLO, S_SKIP
    } eng_state_t;
endpackage

// File: rtl/potctl_linemon.sv
// Line monitor: synchronises SCL and SDA into the clk domain and flags
// SCL edges and start/stop conditions. Assumes clk oversamples SCL by a
// wide margin; the bus idles high, so the chain resets to ones.
module potctl_linemon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_p;
    logic              sda_p;

    // Synchroniser chains plus one previous-value register per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_p     <= 1'b1;
            sda_p     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
            sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
            scl_p     <= scl_chain[STAGES-1];
            sda_p     <= sda_chain[STAGES-1];
        end
    end

    // Edge and condition flags from current and previous samples.
    always_comb begin
        scl_s     = scl_chain[STAGES-1];
        sda_s     = sda_chain[STAGES-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/potctl_decode.sv
// Instruction decode: sorts a 3-bit opcode into read, two-byte write,
// immediate copy and deferred (stop-launched) copy classes.
module potctl_decode (
    input  logic [2:0] op,
    output logic       legal,
    output logic       is_rd,
    output logic       is_wr,
    output logic       is_now
);
    import potctl_pkg::*;

    // Pure combinational classification of the opcode.
    always_comb begin
        legal  = op[2] | op[1];
        is_rd  = (op == OP_RD_WIP) || (op == OP_RD_DR);
        is_wr  = (op == OP_WR_WIP) || (op == OP_WR_DR);
        is_now = (op == OP_XF_D2W);
    end
endmodule

// File: rtl/potctl_slave.sv
// Two-wire command slave for a single digital potentiometer. Receives an
// identification byte, an instruction byte and optional data bytes, issues
// single-cycle requests to a register bank and returns read data. Assumes
// clk runs at least ~16x faster than SCL and the bank answers reads in the
// request cycle. Stores into nonvolatile registers launch at stop.
module potctl_slave #(
    parameter int         WIPER_W     = 10,
    parameter int         SEL_W       = 2,
    parameter logic [3:0] TYPE_ID     = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [1:0]         dev_pins,
    input  logic               nv_busy,
    input  logic [WIPER_W-1:0] rd_data,
    output logic               sda_low,
    output logic               req_valid,
    output logic [2:0]         req_op,
    output logic [SEL_W-1:0]   req_sel,
    output logic [WIPER_W-1:0] req_wdata
);
    import potctl_pkg::*;

    localparam int HI_W = WIPER_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic dec_legal, dec_rd, dec_wr, dec_now;

    eng_state_t         state;
    logic [3:0]         bitn;
    logic [7:0]         shreg;
    logic [7:0]         byte_in;
    logic               txmode;
    logic               ack_pend;
    logic               req_rd;
    logic [WIPER_W-1:0] rd_hold;
    logic [2:0]         cur_op;
    logic [SEL_W-1:0]   cur_sel;
    logic [HI_W-1:0]    hi_hold;
    logic               pend_nv;
    logic [2:0]         pend_op;
    logic [SEL_W-1:0]   pend_sel;
    logic [WIPER_W-1:0] pend_data;

    potctl_linemon #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    potctl_decode u_dec (
        .op(byte_in[7:5]), .legal(dec_legal), .is_rd(dec_rd),
        .is_wr(dec_wr), .is_now(dec_now)
    );

    // Byte as it stands once the current SDA sample is shifted in.
    always_comb byte_in = {shreg[6:0], sda_s};

    // Protocol engine: bit counting, byte handling, SDA drive, requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            bitn      <= '0;
            shreg     <= '0;
            txmode    <= 1'b0;
            ack_pend  <= 1'b0;
            sda_low   <= 1'b0;
            req_valid <= 1'b0;
            req_op    <= '0;
            req_sel   <= '0;
            req_wdata <= '0;
            req_rd    <= 1'b0;
            rd_hold   <= '0;
            cur_op    <= '0;
            cur_sel   <= '0;
            hi_hold   <= '0;
            pend_nv   <= 1'b0;
            pend_op   <= '0;
            pend_sel  <= '0;
            pend_data <= '0;
        end else begin
            req_valid <= 1'b0;
            if (req_valid && req_rd) rd_hold <= rd_data;
            if (start_det) begin
                state    <= S_ID;
                bitn     <= '0;
                txmode   <= 1'b0;
                sda_low  <= 1'b0;
                ack_pend <= 1'b0;
                pend_nv  <= 1'b0;
            end else if (stop_det) begin
                if (pend_nv) begin
                    req_valid <= 1'b1;
                    req_rd    <= 1'b0;
                    req_op    <= pend_op;
                    req_sel   <= pend_sel;
                    req_wdata <= pend_data;
                end
                pend_nv <= 1'b0;
                state   <= S_IDLE;
                txmode  <= 1'b0;
                sda_low <= 1'b0;
            end else if (state != S_IDLE) begin
                if (scl_rise) begin
                    if (bitn != 4'd8) begin
                        bitn  <= bitn + 4'd1;
                        shreg <= txmode ? {shreg[6:0], 1'b0} : byte_in;
                        if (!txmode && bitn == 4'd7) begin
                            ack_pend <= 1'b1;
                            case (state)
                                S_ID: begin
                                    if (byte_in[7:4] == TYPE_ID &&
                                        byte_in[3:2] == dev_pins && !nv_busy) begin
                                        if (byte_in[0]) begin
                                            req_valid <= 1'b1;
                                            req_rd    <= 1'b1;
                                            req_op    <= OP_RD_WIP;
                                            req_sel   <= '0;
                                            req_wdata <= '0;
                                            state     <= S_RHI;
                                        end else begin
                                            state <= S_INSTR;
                                        end
                                    end else begin
                                        ack_pend <= 1'b0;
                                        state    <= S_SKIP;
                                    end
                                end
                                S_INSTR: begin
                                    cur_op  <= byte_in[7:5];
                                    cur_sel <= byte_in[SEL_W-1:0];
                                    if (!dec_legal) begin
                                        ack_pend <= 1'b0;
                                        state    <= S_SKIP;
                                    end else if (dec_wr) begin
                                        state <= S_WHI;
                                    end else if (dec_rd || dec_now) begin
                                        req_valid <= 1'b1;
                                        req_rd    <= dec_rd;
                                        req_op    <= byte_in[7:5];
                                        req_sel   <= byte_in[SEL_W-1:0];
                                        req_wdata <= '0;
                                        state     <= dec_rd ? S_RHI : S_SKIP;
                                    end else begin
                                        pend_nv   <= 1'b1;
                                        pend_op   <= byte_in[7:5];
                                        pend_sel  <= byte_in[SEL_W-1:0];
                                        pend_data <= '0;
                                        state     <= S_SKIP;
                                    end
                                end
                                S_WHI: begin
                                    hi_hold <= byte_in[HI_W-1:0];
                                    state   <= S_WLO;
                                end
                                S_WLO: begin
                                    if (cur_op == OP_WR_WIP) begin
                                        req_valid <= 1'b1;
                                        req_rd    <= 1'b0;
                                        req_op    <= cur_op;
                                        req_sel   <= cur_sel;
                                        req_wdata <= {hi_hold, byte_in};
                                    end else begin
                                        pend_nv   <= 1'b1;
                                        pend_op   <= cur_op;
                                        pend_sel  <= cur_sel;
                                        pend_data <= {hi_hold, byte_in};
                                    end
                                    state <= S_SKIP;
                                end
                                default: begin
                                    ack_pend <= 1'b0;
                                    state    <= S_SKIP;
                                end
                            endcase
                        end
                    end else begin
                        bitn <= '0;
                        if (txmode) begin
                            if (!sda_s && state == S_RHI) begin
                                state <= S_RLO;
                                shreg <= rd_hold[7:0];
                            end else begin
                                state  <= S_SKIP;
                                txmode <= 1'b0;
                            end
                        end else if (state == S_RHI) begin
                            txmode <= 1'b1;
                            shreg  <= {{(8-HI_W){1'b0}}, rd_hold[WIPER_W-1:8]};
                        end
                    end
                end else if (scl_fall) begin
                    if (bitn == 4'd8) sda_low <= txmode ? 1'b0 : ack_pend;
                    else              sda_low <= txmode ? ~shreg[7] : 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/potctl_chk.sv
// Checker for potctl_slave: bus drive discipline, request strobe shape and
// when requests may appear. Bound to every instance of the top module.
module potctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_low,
    input logic       stop_det,
    input logic       in_idle,
    input logic       req_valid,
    input logic [2:0] req_op
);
    // R2
    drive_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> !scl_s);

    // R10
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R6
    store_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'b111 || req_op == 3'b011)) |-> $past(stop_det));

    // R4
    req_legal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_op[2] || req_op[1]));

    // R11
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> !sda_low);
endmodule

bind potctl_slave potctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_low(sda_low),
    .stop_det(stop_det), .in_idle(state == potctl_pkg::S_IDLE),
    .req_valid(req_valid), .req_op(req_op)
);

// File: tb/sim_potctl_slave.sv
// Directed bench: a bus master model, a behavioural register bank with a
// busy window after stores, and one task per scenario.
module sim_potctl_slave;
    localparam int CLK_NS  = 10;
    localparam int Q       = 8;
    localparam int BUSY    = 300;
    localparam logic [7:0] ID_W = 8'h58;  // 0101, pins 10, rw 0
    localparam logic [7:0] ID_R = 8'h59;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] pins = 2'b10;
    logic sda_low, req_valid;
    logic [2:0] req_op;
    logic [1:0] req_sel;
    logic [9:0] req_wdata, rd_data;
    logic sda_line;
    logic nv_busy;

    int tests = 0, fails = 0;
    bit done = 0;
    int req_cnt = 0, busy_cnt = 0;
    logic [2:0] last_op;
    logic [1:0] last_sel;
    logic [9:0] last_data;
    logic [9:0] wcr_m;
    logic [9:0] drm [4];

    always #(CLK_NS/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_low;
    assign nv_busy = (busy_cnt != 0);
    assign rd_data = (req_op == 3'b101) ? wcr_m : drm[req_sel];

    potctl_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .dev_pins(pins), .nv_busy(nv_busy), .rd_data(rd_data),
        .sda_low(sda_low), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_wdata(req_wdata)
    );

    // Register bank model.
    always @(posedge clk) begin
        if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        if (rst_n && req_valid) begin
            req_cnt   <= req_cnt + 1;
            last_op   <= req_op;
            last_sel  <= req_sel;
            last_data <= req_wdata;
            case (req_op)
                3'b110: wcr_m <= req_wdata;
                3'b111: begin drm[req_sel] <= req_wdata; busy_cnt <= BUSY; end
                3'b010: wcr_m <= drm[req_sel];
                3'b011: begin drm[req_sel] <= wcr_m; busy_cnt <= BUSY; end
                default: ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); acked = !sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
        end
        sda_m = !give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk(sda_low == 1'b0, "R11 sda released", sda_low, 0);
        chk(req_cnt == 0, "R11 no request", req_cnt, 0);
    endtask

    task automatic t_bad_id();
        bit a; int n0 = req_cnt;
        bus_start(); send_byte(8'h68, a);
        chk(a == 0, "R1 wrong type nack", a, 0);
        send_byte(8'hC0, a);
        chk(a == 0, "R1 rest ignored", a, 0);
        bus_stop();
        chk(req_cnt == n0, "R1 no request", req_cnt, n0);
        bus_start(); send_byte(8'h54, a); bus_stop();
        chk(a == 0, "R1 pin mismatch nack", a, 0);
    endtask

    task automatic t_wr_wcr();
        bit a0, a1, a2, a3; int n0 = req_cnt;
        bus_start(); send_byte(ID_W, a0); send_byte(8'hC0, a1);
        send_byte(8'hFE, a2); send_byte(8'h5A, a3);
        chk(a0 == 1, "R1 R2 id ack", a0, 1);
        chk(a1 && a2 && a3, "R5 bytes acked", {a1, a2, a3}, 7);
        chk(req_cnt == n0 + 1 && last_op == 3'b110, "R5 R10 request before stop", last_op, 6);
        chk(last_data == 10'h25A, "R5 value upper bits ignored", last_data, 10'h25A);
        bus_stop();
    endtask

    task automatic t_bad_op();
        bit a0, a1; int n0 = req_cnt;
        bus_start(); send_byte(ID_W, a0); send_byte(8'h20, a1); bus_stop();
        chk(a1 == 0, "R4 undefined op nack", a1, 0);
        chk(req_cnt == n0, "R4 no request", req_cnt, n0);
    endtask

    task automatic t_rd_wcr();
        bit a0, a1; logic [7:0] h, l;
        bus_start(); send_byte(ID_W, a0); send_byte(8'hA0, a1);
        recv_byte(h, 1); recv_byte(l, 0); bus_stop();
        chk(a1 == 1, "R7 read op ack", a1, 1);
        chk(h == 8'h02, "R7 high byte", h, 8'h02);
        chk(l == 8'h5A, "R7 low byte", l, 8'h5A);
    endtask

    task automatic t_wr_dr_poll();
        bit a0, a1, a2, a3; int n0 = req_cnt;
        bus_start(); send_byte(ID_W, a0); send_byte(8'hFE, a1);
        send_byte(8'h01, a2); send_byte(8'h23, a3);
        chk(a1 && a2 && a3, "R6 store bytes acked", {a1, a2, a3}, 7);
        chk(req_cnt == n0, "R6 no request before stop", req_cnt, n0);
        bus_stop();
        chk(req_cnt == n0 + 1 && last_op == 3'b111, "R6 request at stop", last_op, 7);
        chk(last_sel == 2'd2, "R4 select with ignored bits", last_sel, 2);
        chk(last_data == 10'h123, "R6 store value", last_data, 10'h123);
        bus_start(); send_byte(ID_W, a0); bus_stop();
        chk(a0 == 0, "R3 busy nack", a0, 0);
        wait (busy_cnt == 0); wq();
        bus_start(); send_byte(ID_W, a0); bus_stop();
        chk(a0 == 1, "R3 ack after busy", a0, 1);
    endtask

    task automatic t_rd_dr();
        bit a0, a1; logic [7:0] h, l;
        bus_start(); send_byte(ID_W, a0); send_byte(8'h82, a1);
        recv_byte(h, 1); recv_byte(l, 0); bus_stop();
        chk({h, l} == 16'h0123, "R7 data register read", {h, l}, 16'h0123);
    endtask

    task automatic t_xfer_and_rw();
        bit a0, a1; int n0 = req_cnt; logic [7:0] h, l;
        bus_start(); send_byte(ID_W, a0); send_byte(8'h42, a1);
        chk(req_cnt == n0 + 1 && last_op == 3'b010, "R9 copy before stop", last_op, 2);
        bus_stop();
        bus_start(); send_byte(ID_R, a0); recv_byte(h, 1); recv_byte(l, 0); bus_stop();
        chk(a0 == 1, "R8 read id ack", a0, 1);
        chk({h, l} == 16'h0123, "R8 direct wiper read", {h, l}, 16'h0123);
        chk(last_op == 3'b101, "R8 read request op", last_op, 5);
    endtask

    task automatic t_abort_store();
        bit a0, a1; int n0 = req_cnt;
        bus_start(); send_byte(ID_W, a0); send_byte(8'h61, a1);
        bus_start(); bus_stop(); wq();
        chk(a1 == 1, "R6 copy op ack", a1, 1);
        chk(req_cnt == n0, "R6 dropped by restart", req_cnt, n0);
    endtask

    initial begin
        wcr_m = '0;
        drm[0] = 10'h111; drm[1] = 10'h222; drm[2] = 10'h333; drm[3] = 10'h044;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_bad_id();
        t_wr_wcr();
        t_bad_op();
        t_rd_wcr();
        t_wr_dr_poll();
        t_rd_dr();
        t_xfer_and_rw();
        t_abort_store();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule